// File: doc/BRIEF.md
# Four-Mode Serial Port

This block is a byte-wide serial port. One shift engine and one clock prescaler serve four framings. A 2-bit mode input selects the framing.

- Mode 0 is a clocked 8-bit exchange. The block drives the serial clock and shifts data out and in at the same time.
- Mode 1 is a half-duplex asynchronous link. A start request sends a frame. When the port is idle, a falling line starts reception.
- Mode 2 is a clocked exchange that puts a low start bit ahead of the 8 data bits.
- Mode 3 is a listener clocked from outside. It waits for a start condition, collects 8 bits, then waits for a stop condition.

Every mode shifts data least significant bit first. Both the data and clock input pins pass through a two-stage synchronizer before use. A transfer in progress shows on the run bit. The end of a transfer raises a sticky done flag and a one-cycle interrupt pulse. The run bit then drops on its own.

The prescaler counts in instruction cycles, and one clock cycle of `clk` is one instruction cycle. With divider value `d` it ticks every `d+1` cycles. In the clocked modes each tick is one half of the serial clock, so the period runs from 2 to 512 cycles. The asynchronous mode uses 8 ticks per bit, so the bit period runs from 8 to 2048 cycles.

Top module: `quad_mode_serial`

## Requirements
- R1: After reset: `sck_out`=1, `sd_out`=1, `busy`=0, `done`=0, `irq`=0, `frame_err`=0, `rx_byte`=0.
- R2: Mode 0 (`mode`=0) starts when `start` is seen while idle. Tick k comes k*(d+1) cycles after acceptance.
  - Odd ticks drive `sck_out` low and put the next transmit bit on `sd_out`, LSB first.
  - Even ticks drive `sck_out` high.
  - `sd_out` and `sck_out` are high before the first odd tick.
  - The clock's low and high halves are each d+1 cycles long.
- R3: Clocked modes sample the synchronized `sd_in` on each rising (even) tick, LSB first. `rx_byte` then holds the last 8 samples.
- R4: Mode 2 (`mode`=2) sends a 9-bit clocked frame: a 0 start bit, then the 8 data bits LSB first. It finishes on tick 18, and `rx_byte` holds samples 2 to 9.
- R5: Mode 1 transmit frame, with one bit lasting 8*(d+1) cycles:
  - The start bit (0) begins right after acceptance.
  - The 8 data bits follow, LSB first, then a stop bit (1).
  - The transfer finishes 80 ticks after acceptance.
  - `sck_out` stays high throughout.
  - `rx_byte` is left unchanged.
- R6: In mode 1 while idle, a falling synchronized `sd_in` starts reception. If the line is high again 4 ticks later, the frame is dropped: `busy` returns to 0 and `done` is not set.
- R7: Mode 1 receive samples the data bits 12, 20, … 68 ticks after the falling edge and the stop bit at 76 ticks. At 76 ticks it loads `rx_byte` and sets `frame_err` = 1 if the stop bit is low, 0 if it is high.
- R8: Mode 3 reception:
  - Start: `sd_in` falls while `sck_in` is high.
  - Each of the next 8 rising edges of `sck_in` samples a data bit.
  - Stop: `sd_in` rises while `sck_in` is high. The stop loads `rx_byte` and completes the transfer.
  - `sd_out` and `sck_out` stay high.
- R9: On completion `done` is set and `irq` pulses for exactly that cycle. `done` stays set until `flag_clr` or the next accepted `start`. `flag_clr` also clears `frame_err`.
- R10: `start` has no effect while `busy` is 1, or when `mode`=3.
- R11: `busy` is 1 from acceptance (or start detection) until the completion cycle.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Framing select: 0 clocked, 1 asynchronous, 2 clocked with start bit, 3 external-clock listener |
| div | input | 8 | Prescaler setting d, tick every d+1 cycles |
| tx_byte | input | 8 | Byte to transmit, taken at acceptance |
| start | input | 1 | Request to begin a transfer |
| flag_clr | input | 1 | Clears `done` and `frame_err` |
| sd_in | input | 1 | Serial data input pin |
| sck_in | input | 1 | Serial clock input pin (mode 3) |
| sd_out | output | 1 | Serial data output pin, idle high |
| sck_out | output | 1 | Serial clock output pin, idle high |
| rx_byte | output | 8 | Last received byte |
| busy | output | 1 | Run bit |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion pulse |
| frame_err | output | 1 | Stop bit of the last asynchronous reception was low |

## Verification
The clocked modes are driven at prescaler settings 0, 2 and 5. The setting-0 run checks the shortest legal half-period. The wider settings show whether the data edge lines up with the falling clock and the sample with the rising clock. Transmit bytes with their high and low bits set differently expose any bit-order reversal. The asynchronous receiver is given three inputs:
- a clean frame,
- a frame with a low stop bit,
- a start pulse too short to survive the mid-bit recheck.

Together these separate the error-flag path from the abort path. A start request in the middle of a transfer, and another in listener mode, show that a busy or passive port keeps its waveform.

// File: rtl/qms_pkg.sv
package qms_pkg;
  typedef enum logic [1:0] {
    MD_CLK  = 2'd0,
    MD_ASYN = 2'd1,
    MD_SBIT = 2'd2,
    MD_LSTN = 2'd3
  } qms_mode_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CLK   = 3'd1,
    ST_ATX   = 3'd2,
    ST_ARX   = 3'd3,
    ST_LDATA = 3'd4,
    ST_LSTOP = 3'd5
  } qms_state_t;
endpackage

// File: rtl/qms_prescale.sv
module qms_prescale #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en)
      cnt_d = (cnt_q == div) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && !clr && (cnt_q == div);
endmodule

// File: rtl/qms_sync.sv
module qms_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d[b]};
    end
    assign q[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/quad_mode_serial.sv
module quad_mode_serial
  import qms_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 8,
  parameter int OVS         = 8,   // ticks per asynchronous bit, power of two
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [DIV_W-1:0]  div,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              start,
  input  logic              flag_clr,
  input  logic              sd_in,
  input  logic              sck_in,
  output logic              sd_out,
  output logic              sck_out,
  output logic [DATA_W-1:0] rx_byte,
  output logic              busy,
  output logic              done,
  output logic              irq,
  output logic              frame_err
);
  localparam int TK_W   = $clog2(OVS * (DATA_W + 2) + 1);
  localparam int OVS_LG = $clog2(OVS);
  localparam int BC_W   = $clog2(DATA_W);
  localparam logic [TK_W-1:0]   K_CLK_END  = TK_W'(2 * DATA_W);
  localparam logic [TK_W-1:0]   K_SBIT_END = TK_W'(2 * (DATA_W + 1));
  localparam logic [TK_W-1:0]   K_ATX_END  = TK_W'(OVS * (DATA_W + 2));
  localparam logic [TK_W-1:0]   K_ARX_END  = TK_W'(OVS * (DATA_W + 2) - OVS / 2);
  localparam logic [TK_W-1:0]   K_HALF     = TK_W'(OVS / 2);
  localparam logic [OVS_LG-1:0] K_HALF_LO  = OVS_LG'(OVS / 2);
  localparam logic [BC_W-1:0]   BC_LAST    = BC_W'(DATA_W - 1);

  qms_state_t        st_q, st_d;
  qms_mode_t         md_q, md_d;
  logic              sck_q, sck_d, sdo_q, sdo_d;
  logic [DATA_W:0]   txs_q, txs_d;
  logic [DATA_W-1:0] rxs_q, rxs_d, rxb_q, rxb_d;
  logic [TK_W-1:0]   tcnt_q, tcnt_d, kk;
  logic [BC_W-1:0]   bcnt_q, bcnt_d;
  logic              done_q, done_d, irq_q, irq_d, ferr_q, ferr_d;
  logic              sdp_q, sckp_q;
  logic [1:0]        sync_q;
  logic              sd_s, sck_s, tick, pre_en, pre_clr;
  logic              sd_fall, sd_rise, sck_rise;

  qms_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_in, sd_in}), .q(sync_q));
  assign sd_s  = sync_q[0];
  assign sck_s = sync_q[1];

  assign pre_en = (st_q == ST_CLK) || (st_q == ST_ATX) || (st_q == ST_ARX);
  qms_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en(pre_en), .clr(pre_clr), .div(div), .tick(tick));

  assign sd_fall  = sdp_q && !sd_s;
  assign sd_rise  = !sdp_q && sd_s;
  assign sck_rise = !sckp_q && sck_s;
  assign kk       = tcnt_q + 1'b1;

  always_comb begin
    st_d = st_q;  md_d = md_q;  sck_d = sck_q;  sdo_d = sdo_q;
    txs_d = txs_q;  rxs_d = rxs_q;  rxb_d = rxb_q;
    tcnt_d = tcnt_q;  bcnt_d = bcnt_q;
    done_d = done_q;  ferr_d = ferr_q;  irq_d = 1'b0;  pre_clr = 1'b0;
    if (flag_clr) begin
      done_d = 1'b0;
      ferr_d = 1'b0;
    end
    unique case (st_q)
      ST_IDLE: begin
        if (start && mode != MD_LSTN) begin
          md_d = qms_mode_t'(mode);  done_d = 1'b0;  tcnt_d = '0;  pre_clr = 1'b1;
          if (mode == MD_ASYN) begin
            st_d = ST_ATX;  sdo_d = 1'b0;  txs_d = {1'b1, tx_byte};
          end else begin
            st_d  = ST_CLK;
            txs_d = (mode == MD_SBIT) ? {tx_byte, 1'b0} : {1'b1, tx_byte};
          end
        end else if (mode == MD_ASYN && sd_fall) begin
          st_d = ST_ARX;  md_d = MD_ASYN;  tcnt_d = '0;  pre_clr = 1'b1;
        end else if (mode == MD_LSTN && sck_s && sd_fall) begin
          st_d = ST_LDATA;  md_d = MD_LSTN;  bcnt_d = '0;
        end
      end
      ST_CLK: if (tick) begin
        tcnt_d = kk;
        if (!tcnt_q[0]) begin
          sck_d = 1'b0;  sdo_d = txs_q[0];  txs_d = {1'b1, txs_q[DATA_W:1]};
        end else begin
          sck_d = 1'b1;  rxs_d = {sd_s, rxs_q[DATA_W-1:1]};
          if (kk == ((md_q == MD_SBIT) ? K_SBIT_END : K_CLK_END)) begin
            st_d = ST_IDLE;  sdo_d = 1'b1;  rxb_d = {sd_s, rxs_q[DATA_W-1:1]};
            done_d = 1'b1;  irq_d = 1'b1;
          end
        end
      end
      ST_ATX: if (tick) begin
        tcnt_d = kk;
        if (kk == K_ATX_END) begin
          st_d = ST_IDLE;  sdo_d = 1'b1;  done_d = 1'b1;  irq_d = 1'b1;
        end else if (kk[OVS_LG-1:0] == '0) begin
          sdo_d = txs_q[0];  txs_d = {1'b1, txs_q[DATA_W:1]};
        end
      end
      ST_ARX: if (tick) begin
        tcnt_d = kk;
        if (kk[OVS_LG-1:0] == K_HALF_LO) begin
          if (kk == K_HALF) begin
            if (sd_s) st_d = ST_IDLE;             // start bit did not hold
          end else if (kk == K_ARX_END) begin
            st_d = ST_IDLE;  rxb_d = rxs_q;  ferr_d = !sd_s;
            done_d = 1'b1;  irq_d = 1'b1;
          end else begin
            rxs_d = {sd_s, rxs_q[DATA_W-1:1]};
          end
        end
      end
      ST_LDATA: if (sck_rise) begin
        rxs_d  = {sd_s, rxs_q[DATA_W-1:1]};
        bcnt_d = bcnt_q + 1'b1;
        if (bcnt_q == BC_LAST) st_d = ST_LSTOP;
      end
      ST_LSTOP: if (sck_s && sd_rise) begin
        st_d = ST_IDLE;  rxb_d = rxs_q;  done_d = 1'b1;  irq_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  md_q <= MD_CLK;  sck_q <= 1'b1;  sdo_q <= 1'b1;
      txs_q <= '1;  rxs_q <= '0;  rxb_q <= '0;  tcnt_q <= '0;  bcnt_q <= '0;
      done_q <= 1'b0;  irq_q <= 1'b0;  ferr_q <= 1'b0;  sdp_q <= 1'b1;  sckp_q <= 1'b1;
    end else begin
      st_q <= st_d;  md_q <= md_d;  sck_q <= sck_d;  sdo_q <= sdo_d;
      txs_q <= txs_d;  rxs_q <= rxs_d;  rxb_q <= rxb_d;  tcnt_q <= tcnt_d;  bcnt_q <= bcnt_d;
      done_q <= done_d;  irq_q <= irq_d;  ferr_q <= ferr_d;  sdp_q <= sd_s;  sckp_q <= sck_s;
    end
  end

  assign sd_out    = sdo_q;
  assign sck_out   = sck_q;
  assign rx_byte   = rxb_q;
  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign irq       = irq_q;
  assign frame_err = ferr_q;

  a_r9_irq_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (done && !busy));
  a_r11_irq_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(busy));
  a_r2_clock_idles_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck_out);
  a_r5_async_no_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && md_q == MD_ASYN) |-> sck_out);
  a_r8_listener_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && md_q == MD_LSTN) |-> (sd_out && sck_out));
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(md_q));
  a_r7_ferr_from_async: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_err) |-> $past(st_q == ST_ARX));
endmodule

// File: tb/sim_quad_mode_serial.sv
module sim_quad_mode_serial;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [7:0] div = 8'd0;
  logic [7:0] tx_byte = 8'd0;
  logic       start = 1'b0, flag_clr = 1'b0, sd_in = 1'b1, sck_in = 1'b1;
  logic       sd_out, sck_out, busy, done, irq, frame_err;
  logic [7:0] rx_byte;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  quad_mode_serial u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .div(div), .tx_byte(tx_byte),
    .start(start), .flag_clr(flag_clr), .sd_in(sd_in), .sck_in(sck_in),
    .sd_out(sd_out), .sck_out(sck_out), .rx_byte(rx_byte), .busy(busy),
    .done(done), .irq(irq), .frame_err(frame_err));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic pulse_clr;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
  endtask

  // Drives one master-side transfer and compares {sck,sd,busy,done,irq} each cycle.
  task automatic run_master(input logic [1:0] md, input int dv, input logic [7:0] tx,
                            input logic [7:0] rxd, input bit chk_rx, input int poke);
    int p, nb, endk;
    logic [8:0] ftx, frx;
    logic [7:0] rx_before;
    string tag;
    p = dv + 1;
    nb = (md == 2'd2) ? 9 : 8;
    endk = (md == 2'd1) ? 80 : 2 * nb;
    ftx = (md == 2'd2) ? {tx, 1'b0} : {1'b0, tx};
    frx = (md == 2'd2) ? {rxd, 1'b0} : {1'b0, rxd};
    tag = (md == 2'd0) ? "R2" : (md == 2'd2) ? "R4" : "R5";
    rx_before = rx_byte;
    sd_in = 1'b1;
    @(negedge clk); mode = md; div = 8'(dv); tx_byte = tx; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int m = 0; m <= endk * p + 1; m++) begin
      int k, j;
      logic es, ed, eb, en, ei;
      k = m / p;
      if (md == 2'd1) begin
        es = 1'b1;
        ed = (k < 8) ? 1'b0 : (k < 72) ? tx[(k - 8) / 8] : 1'b1;
      end else if (k == 0 || k >= endk) begin
        es = 1'b1; ed = 1'b1;
      end else begin
        es = (k % 2 == 0); ed = ftx[(k - 1) / 2];
      end
      eb = (k < endk);             // R11
      en = (k >= endk);            // R9
      ei = (m == endk * p);        // R9
      chk({sck_out, sd_out, busy, done, irq} == {es, ed, eb, en, ei}, tag,
          $sformatf("pins@m=%0d {sck,sd,busy,done,irq}", m),
          int'({sck_out, sd_out, busy, done, irq}), int'({es, ed, eb, en, ei}));
      if (m == poke) begin           // R10: request while busy
        start = 1'b1; tx_byte = ~tx; mode = 2'd1;
      end else begin
        start = 1'b0; mode = md;
      end
      j = (k - 1) / 2;
      if (md != 2'd1 && k >= 1 && j < nb) sd_in = frx[j];
      else sd_in = 1'b1;
      @(negedge clk);
    end
    start = 1'b0; sd_in = 1'b1;
    if (md == 2'd1)
      chk(rx_byte == rx_before, "R5", "rx_byte untouched by send", rx_byte, rx_before);
    else if (chk_rx)
      chk(rx_byte == rxd, (md == 2'd0) ? "R3" : "R4", "received byte", rx_byte, rxd);
    wait_n(3);
  endtask

  task automatic run_async_rx(input int dv, input logic [7:0] data, input logic stopb,
                              input bit glitch);
    int p;
    logic [7:0] rx_before;
    p = dv + 1;
    sd_in = 1'b1; mode = 2'd1; div = 8'(dv);
    wait_n(4);
    pulse_clr();
    rx_before = rx_byte;
    sd_in = 1'b0;
    if (glitch) begin
      wait_n(2 * p); sd_in = 1'b1;
      wait_n(14 * p);
      chk(!busy, "R6", "busy after short start", busy, 0);
      chk(!done, "R6", "done after short start", done, 0);
      chk(rx_byte == rx_before, "R6", "rx_byte after short start", rx_byte, rx_before);
    end else begin
      wait_n(8 * p);
      for (int i = 0; i < 8; i++) begin
        sd_in = data[i];
        wait_n(4 * p);
        if (i == 3) chk(busy, "R11", "busy mid frame", busy, 1);
        wait_n(4 * p);
      end
      sd_in = stopb;
      wait_n(8 * p);
      sd_in = 1'b1;
      wait_n(10);
      chk(done && !busy, "R7", "done/busy after frame", {done, busy}, 2'b10);
      chk(rx_byte == data, "R7", "async byte", rx_byte, data);
      chk(frame_err == !stopb, "R7", "frame_err", frame_err, !stopb);
    end
  endtask

  task automatic lstn_phase(input logic c, input logic d);
    sck_in = c; sd_in = d;
    wait_n(6);
    chk(sd_out && sck_out, "R8", "listener keeps outputs high", {sck_out, sd_out}, 2'b11);
  endtask

  task automatic run_listen(input logic [7:0] data);
    sck_in = 1'b1; sd_in = 1'b1; mode = 2'd3;
    wait_n(6);
    pulse_clr();
    lstn_phase(1'b1, 1'b0);
    chk(busy, "R11", "busy after start condition", busy, 1);
    for (int i = 0; i < 8; i++) begin
      lstn_phase(1'b0, data[i]);
      lstn_phase(1'b1, data[i]);
    end
    lstn_phase(1'b0, 1'b0);
    lstn_phase(1'b1, 1'b0);
    chk(busy && !done, "R8", "waiting for stop", {busy, done}, 2'b10);
    lstn_phase(1'b1, 1'b1);
    chk(done && !busy, "R8", "done after stop", {done, busy}, 2'b10);
    chk(rx_byte == data, "R8", "listener byte", rx_byte, data);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    wait_n(3);
    // R1 reset state
    chk({sck_out, sd_out, busy, done, irq, frame_err} == 6'b110000, "R1", "pins in reset",
        {sck_out, sd_out, busy, done, irq, frame_err}, 6'b110000);
    chk(rx_byte == 8'h00, "R1", "rx_byte in reset", rx_byte, 0);
    @(negedge clk); rst_n = 1'b1;
    wait_n(3);
    chk({sck_out, sd_out, busy, done} == 4'b1100, "R1", "pins after release",
        {sck_out, sd_out, busy, done}, 4'b1100);

    run_master(2'd0, 0, 8'hA5, 8'h00, 1'b0, -1);
    run_master(2'd0, 2, 8'h3C, 8'hC6, 1'b1, 5);     // R10 request at m=5
    run_master(2'd0, 5, 8'h81, 8'h7E, 1'b1, 40);    // R10 request later on
    run_master(2'd2, 2, 8'h5A, 8'h93, 1'b1, -1);
    run_master(2'd2, 0, 8'hF0, 8'h00, 1'b0, -1);

    // R9 flag clear
    chk(done, "R9", "done held before clear", done, 1);
    pulse_clr();
    chk(!done, "R9", "done after flag_clr", done, 0);

    run_master(2'd1, 1, 8'hB2, 8'h00, 1'b0, 30);    // R5 with R10 request
    run_master(2'd1, 0, 8'h01, 8'h00, 1'b0, -1);

    run_async_rx(1, 8'h4D, 1'b1, 1'b0);
    run_async_rx(2, 8'hE1, 1'b0, 1'b0);             // R7 low stop
    pulse_clr();
    chk(!frame_err, "R9", "frame_err after flag_clr", frame_err, 0);
    run_async_rx(1, 8'h00, 1'b1, 1'b1);             // R6 short start

    run_listen(8'h96);
    run_listen(8'h3B);

    // R10: request in listener mode is ignored
    pulse_clr();
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_n(20);
    chk(!busy && !done, "R10", "start in mode 3", {busy, done}, 0);
    chk(sd_out && sck_out, "R10", "pins after mode-3 start", {sck_out, sd_out}, 2'b11);

    summary();
    $finish;
  end
endmodule